// File: doc/BRIEF.md
# Register-Mapped I2C Target with Write-Gated Acknowledge

This block is the bus-facing front end of a small register-mapped peripheral. It watches an oversampled two-wire serial bus (clock and data, both sampled by the system clock through synchronizers), finds start and stop conditions, and checks the first byte of each transfer against a fixed 4-bit device identifier and a 3-bit select field. When the byte matches, it takes part in the transfer as a target. In a write, the first data byte loads an 8-bit register pointer and the bytes after it are stored into a flop-based register file. In a read, bytes are returned from the pointer, which steps forward after each one. The block drives the data line only through an open-drain enable: it pulls the line low or releases it.

Whether the block acknowledges a byte depends on its own state. A write-enable latch, held in one bit of a protection register, decides whether ordinary data bytes are taken. The protection register itself can always be written, so the latch can be set. That register takes exactly one byte per transfer, and any byte after it is refused. In a read, the block keeps sending bytes only while the controller acknowledges them.

Top module: `i2c_gated_slave`

## Requirements
- R1: A stop condition (data rising while clock is high) ends any transfer. The block then releases the data line and waits in standby for a new start. A start condition is data falling while clock is high.
- R2: Before the first start condition, no clock or data activity makes the block drive the data line.
- R3: A start condition that arrives in the middle of a transfer, even in the middle of a byte, abandons that transfer without storing the partial byte. Address reception begins again.
- R4: The first byte after a start is acknowledged only when bits 7..4 equal 1101 and bits 3..1 equal 111. Bit 0 selects a read when it is 1, so the byte is 0xDE for a write and 0xDF for a read. On any other value the data line stays released, and the block ignores the bus until the next start.
- R5: In a write, the first data byte after the address byte loads the 8-bit register pointer. This byte is always acknowledged.
- R6: The write-enable latch is bit 1 of the protection register at address 0x3F. While that bit is 0, every data byte after the pointer byte is refused (not acknowledged), and no register at an address other than 0x3F changes.
- R7: A data byte aimed at address 0x3F is acknowledged and stored whatever the latch holds. Every later data byte of that same write is refused and discarded.
- R8: With the latch set, each accepted data byte is stored at the pointer, and the pointer then steps by one (modulo 256). The register file spans addresses 0x00 to 0x3F. Accepted writes to higher addresses store nothing.
- R9: A read returns the register at the pointer, most significant bit first, and the pointer then steps by one. Addresses from 0x40 up read as 0x00.
- R10: After each read byte the block releases the data line for the acknowledge clock. It sends the next byte only if the controller pulled the line low. After a missing acknowledge it stops driving until the next start.
- R11: The data-line enable changes only while the synchronized clock is low.
- R12: After reset the data line is released and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions check on every clock the rules that hold at any moment. The enable moves only while the clock is low. A stop forces standby and a released line, and a start forces address reception. An address mismatch leaves the line released. No write lands outside the protection register while the latch is clear, and the protection register takes at most one byte per transfer. The bench scenarios show what needs a whole transfer to see: which byte in a burst is refused, the values read back after refused or aborted writes, pointer stepping across the protection register and past the end of the register file, and the end of a read burst on a missing acknowledge.

// File: rtl/i2c_gs_pkg.sv
// Shared types for the gated-acknowledge I2C target.
// Assumes: nothing beyond standard SystemVerilog.
package i2c_gs_pkg;

    // Protocol phase of the target engine.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // standby, waiting for a start
        ST_ADDR = 3'd1,  // shifting in the address byte
        ST_ACK  = 3'd2,  // ninth clock of a byte the target received
        ST_WR   = 3'd3,  // shifting in a write data byte
        ST_RD   = 3'd4,  // shifting out a read data byte
        ST_MACK = 3'd5   // ninth clock of a byte the target sent
    } gs_state_t;

    // Width of a bus byte.
    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_gs_sync.sv
// Bus input conditioner: passes clock and data through a flop chain,
// then compares each line with its value one cycle earlier to find
// clock edges and start/stop conditions.
// Assumes: STAGES >= 2, and the bus idles high, so the flops reset to 1.
module i2c_gs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Resynchronize both lines into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end

    // Hold the previous synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[STAGES-1];
            sda_q <= sda_ff[STAGES-1];
        end
    end

    // Decode edges and bus conditions.
    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_gs_regfile.sv
// Flop-based register file behind the target, with one write port and
// one combinational read port. It also exposes the write-enable latch bit.
// Assumes: DEPTH < 2**AW. Addresses at or above DEPTH read 0 and drop writes.
module i2c_gs_regfile #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int DEPTH     = 64,
    parameter int PROT_ADDR = 63,
    parameter int WEL_BIT   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          wel
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // One storage word; loads when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_en && (wr_addr == AW'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Read mux with zero fill past the end of the file.
    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_data = mem[rd_addr[IW-1:0]];
        end else begin
            rd_data = '0;
        end
        wel = mem[PROT_ADDR][WEL_BIT];
    end

endmodule

// File: rtl/i2c_gs_gate.sv
// Acknowledge gate for a received write byte. It decides whether the
// byte is acknowledged, stored, used as the pointer, or refused.
// Assumes: the caller applies the outputs only at the byte decision point.
module i2c_gs_gate #(
    parameter int AW        = 8,
    parameter int PROT_ADDR = 63
) (
    input  logic          ptr_valid,
    input  logic [AW-1:0] ptr,
    input  logic          wel,
    input  logic          prot_done,
    output logic          ack,
    output logic          load_ptr,
    output logic          do_write,
    output logic          step_ptr,
    output logic          set_prot
);

    localparam logic [AW-1:0] PROT_A = AW'(PROT_ADDR);

    // Priority: pointer byte, closed protection write, protection target,
    // latch-gated ordinary write.
    always_comb begin
        ack      = 1'b0;
        load_ptr = 1'b0;
        do_write = 1'b0;
        step_ptr = 1'b0;
        set_prot = 1'b0;
        if (!ptr_valid) begin
            ack      = 1'b1;
            load_ptr = 1'b1;
        end else if (prot_done) begin
            ack      = 1'b0;
        end else if (ptr == PROT_A) begin
            ack      = 1'b1;
            do_write = 1'b1;
            set_prot = 1'b1;
        end else if (wel) begin
            ack      = 1'b1;
            do_write = 1'b1;
            step_ptr = 1'b1;
        end
    end

endmodule

// File: rtl/i2c_gated_slave.sv
// Top of the gated-acknowledge I2C target. It holds the protocol engine
// and instantiates the input conditioner, the acknowledge gate and the
// register file. The data line is driven only through sda_oe (open drain).
// Assumes: the controller never stretches the clock and keeps every clock
// phase well above SYNC_STAGES+1 system clocks.
module i2c_gated_slave #(
    parameter logic [3:0] DEV_ID      = 4'b1101,
    parameter logic [2:0] SEL_ID      = 3'b111,
    parameter int         REG_DEPTH   = 64,
    parameter int         PROT_ADDR   = 63,
    parameter int         WEL_BIT     = 1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import i2c_gs_pkg::*;

    localparam int         AW    = 8;
    localparam int         CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [6:0] MATCH = {DEV_ID, SEL_ID};
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    gs_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [AW-1:0]     ptr;
    logic              ptr_valid;
    logic              prot_done;
    logic              is_read;
    logic              mack;

    logic              g_ack, g_load, g_write, g_step, g_prot;
    logic              wel;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic              byte_end;

    i2c_gs_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_s    (sda_s)
    );

    i2c_gs_gate #(
        .AW       (AW),
        .PROT_ADDR(PROT_ADDR)
    ) u_gate (
        .ptr_valid(ptr_valid),
        .ptr      (ptr),
        .wel      (wel),
        .prot_done(prot_done),
        .ack      (g_ack),
        .load_ptr (g_load),
        .do_write (g_write),
        .step_ptr (g_step),
        .set_prot (g_prot)
    );

    i2c_gs_regfile #(
        .AW       (AW),
        .DW       (BYTE_W),
        .DEPTH    (REG_DEPTH),
        .PROT_ADDR(PROT_ADDR),
        .WEL_BIT  (WEL_BIT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(ptr),
        .rd_data(rd_data),
        .wel    (wel)
    );

    // Register-file write strobe at the end of an accepted write byte.
    always_comb begin
        byte_end = scl_fall && (cnt == FULL);
        wr_en    = (state == ST_WR) && byte_end && g_write
                   && !start_det && !stop_det;
        wr_addr  = ptr;
        wr_data  = shreg;
    end

    // Protocol engine: conditions first, then per-phase handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            ptr_valid <= 1'b0;
            prot_done <= 1'b0;
            is_read   <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            cnt       <= '0;
            ptr_valid <= 1'b0;
            prot_done <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sda_oe <= 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                        if (shreg[7:1] == MATCH) begin
                            sda_oe  <= 1'b1;
                            is_read <= shreg[0];
                            state   <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt    <= '0;
                        sda_oe <= g_ack;
                        state  <= ST_ACK;
                        if (g_load) begin
                            ptr       <= shreg;
                            ptr_valid <= 1'b1;
                        end
                        if (g_step) begin
                            ptr <= ptr + 1'b1;
                        end
                        if (g_prot) begin
                            prot_done <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (is_read) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt == FULL) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            mack   <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            txreg  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_gs_chk.sv
// Property checker for the gated-acknowledge I2C target, bound to the top.
// Assumes: it is connected to the top's internal nets through the bind below.
module i2c_gs_chk #(
    parameter logic [6:0] MATCH     = 7'h6F,
    parameter int         PROT_ADDR = 63
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  scl_fall,
    input logic                  start_det,
    input logic                  stop_det,
    input i2c_gs_pkg::gs_state_t state,
    input logic [3:0]            cnt,
    input logic [7:0]            shreg,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic                  wel,
    input logic                  prot_done,
    input logic                  sda_oe
);
    import i2c_gs_pkg::*;

    localparam logic [7:0] PROT_A = 8'(PROT_ADDR);

    AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R11

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe)); // R1

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && cnt == 4'd0)); // R3

    AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && cnt == 4'd8 && shreg[7:1] != MATCH)
        |=> (state == ST_IDLE && !sda_oe)); // R4

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != PROT_A) |-> wel); // R6

    AST_PROT_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PROT_A) |-> !prot_done); // R7

endmodule

bind i2c_gated_slave i2c_gs_chk #(
    .MATCH    ({DEV_ID, SEL_ID}),
    .PROT_ADDR(PROT_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .state    (state),
    .cnt      (cnt),
    .shreg    (shreg),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wel      (wel),
    .prot_done(prot_done),
    .sda_oe   (sda_oe)
);

// File: tb/i2c_gated_slave_tb.sv
// Self-checking bench: a behavioural bus controller drives transfers, and a
// behavioural register model (array, integers) predicts each acknowledge
// and each read byte. A per-clock monitor checks line release and enable
// timing.
module i2c_gated_slave_tb;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic mon_rel = 1'b0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;

    int checks = 0;
    int bad = 0;

    // Reference model state.
    logic [7:0] mdl_mem [256];
    int         mdl_ptr = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_gated_slave u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl),
        .sda_i (sda_line),
        .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock monitor: release while the controller drives (R2, R10)
    // and no enable change while the bus clock is high (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_rel) chk("R10 release", {7'd0, sda_oe}, 8'd0);
            if (sda_oe !== prev_oe && scl && prev_scl) chk("R11 oe edge", 8'd1, 8'd0);
        end
        prev_oe  <= sda_oe;
        prev_scl <= scl;
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wc(Q); sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q);
        mon_rel = 1'b1; sda_m = 1'b0; wc(Q);
        scl = 1'b0; mon_rel = 1'b0;
    endtask

    task automatic bus_stop();
        wc(Q); sda_m = 1'b0; mon_rel = 1'b1; wc(Q);
        scl = 1'b1; wc(Q); sda_m = 1'b1; wc(Q); mon_rel = 1'b0;
    endtask

    task automatic put_bit(input logic b);
        wc(Q); sda_m = b; mon_rel = 1'b1; wc(Q);
        scl = 1'b1; wc(2 * Q);
        mon_rel = 1'b0; scl = 1'b0;
    endtask

    task automatic get_bit(output logic v);
        wc(Q); sda_m = 1'b1; wc(Q);
        scl = 1'b1; wc(Q); v = sda_line; wc(Q);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v);
        ack = ~v;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            d[i] = v;
        end
        put_bit(~give_ack);
    endtask

    // Write transfer: address 0xDE, then the bytes in q, each acknowledge predicted.
    task automatic do_write(input logic [7:0] q [$], input string req);
        logic ack;
        logic exp;
        logic pv = 1'b0;
        logic pd = 1'b0;
        bus_start();
        send_byte(8'hDE, ack);
        chk("R4 write address ack", {7'd0, ack}, 8'd1);
        foreach (q[i]) begin
            if (!pv) begin
                exp = 1'b1; mdl_ptr = q[i]; pv = 1'b1;
            end else if (pd) begin
                exp = 1'b0;
            end else if (mdl_ptr == 63) begin
                exp = 1'b1; mdl_mem[63] = q[i]; pd = 1'b1;
            end else if (mdl_mem[63][1]) begin
                exp = 1'b1;
                if (mdl_ptr < 64) mdl_mem[mdl_ptr] = q[i];
                mdl_ptr = (mdl_ptr + 1) % 256;
            end else begin
                exp = 1'b0;
            end
            send_byte(q[i], ack);
            chk(req, {7'd0, ack}, {7'd0, exp});
        end
        bus_stop();
    endtask

    // Read transfer of n bytes from the current pointer; last byte not acknowledged.
    task automatic do_read(input int n, input string req);
        logic ack;
        logic [7:0] d;
        logic [7:0] e;
        bus_start();
        send_byte(8'hDF, ack);
        chk("R4 read address ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            e = (mdl_ptr < 64) ? mdl_mem[mdl_ptr] : 8'h00;
            mdl_ptr = (mdl_ptr + 1) % 256;
            chk(req, d, e);
        end
        bus_stop();
    endtask

    task automatic bad_addr(input logic [7:0] a);
        logic ack;
        bus_start();
        send_byte(a, ack);
        chk("R4 mismatch nack", {7'd0, ack}, 8'd0);
        put_bit(1'b1);
        chk("R4 silent after mismatch", {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic v;
        logic [7:0] q [$];
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'h00;
        wc(6);
        rst_n = 1'b1;
        wc(4);
        chk("R12 reset release", {7'd0, sda_oe}, 8'd0);

        // R2: clocked traffic with no start condition.
        scl = 1'b0;
        for (int i = 0; i < 9; i++) put_bit(((8'hDE >> (i % 8)) & 1) != 0);
        wc(Q); sda_m = 1'b1; wc(Q); scl = 1'b1; wc(Q);
        chk("R2 idle before start", {7'd0, sda_oe}, 8'd0);

        // R4: identifier or select mismatch.
        bad_addr(8'hA0);
        bad_addr(8'hDC);
        bad_addr(8'h5E);

        // R5, R6: latch clear, data refused, register untouched.
        q = '{8'h05, 8'h55, 8'h66};
        do_write(q, "R6 refused with latch clear");
        q = '{8'h05};
        do_write(q, "R5 pointer byte ack");
        do_read(2, "R6 R12 unchanged register");

        // R7: protection register, one byte only.
        q = '{8'h3F, 8'h02, 8'hFF};
        do_write(q, "R7 single protection byte");
        q = '{8'h3F};
        do_write(q, "R5 pointer byte ack");
        do_read(1, "R7 protection value");

        // R8, R9, R10: burst write and read back.
        q = '{8'h10, 8'hA1, 8'hB2, 8'hC3};
        do_write(q, "R8 burst write ack");
        q = '{8'h10};
        do_write(q, "R5 pointer byte ack");
        do_read(3, "R9 R10 burst read");

        // R7, R8: burst that walks into the protection register.
        q = '{8'h3E, 8'h77, 8'h02, 8'h44};
        do_write(q, "R7 R8 walk into protection");
        q = '{8'h3E};
        do_write(q, "R5 pointer byte ack");
        do_read(2, "R7 R9 walk read back");

        // R8, R9: past the end of the file.
        q = '{8'h40, 8'h12};
        do_write(q, "R8 out of range write ack");
        q = '{8'h40};
        do_write(q, "R5 pointer byte ack");
        do_read(1, "R9 out of range reads zero");

        // R3: start in the middle of a data byte abandons it.
        bus_start();
        send_byte(8'hDE, ack);
        chk("R3 address ack", {7'd0, ack}, 8'd1);
        send_byte(8'h20, ack);
        chk("R3 pointer ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(8'hDE, ack);
        chk("R3 restart address ack", {7'd0, ack}, 8'd1);
        send_byte(8'h20, ack);
        chk("R3 restart pointer ack", {7'd0, ack}, 8'd1);
        mdl_ptr = 8'h20;
        bus_stop();
        do_read(1, "R3 partial byte not stored");

        // R6: clear the latch, then ordinary writes are refused.
        q = '{8'h3F, 8'h00};
        do_write(q, "R7 latch clear write");
        q = '{8'h11, 8'hEE};
        do_write(q, "R6 refused after clear");
        q = '{8'h10};
        do_write(q, "R5 pointer byte ack");
        do_read(2, "R6 values kept");

        // R1, R10: a read ended by a missing acknowledge leaves the line free.
        bus_start();
        send_byte(8'hDF, ack);
        chk("R10 read address ack", {7'd0, ack}, 8'd1);
        get_bit(v);
        for (int i = 0; i < 7; i++) get_bit(v);
        put_bit(1'b1);
        get_bit(v);
        chk("R10 no drive after nack", {7'd0, ~v}, 8'd0);
        bus_stop();
        wc(8);
        chk("R1 released after stop", {7'd0, sda_oe}, 8'd0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule